// File: doc/BRIEF.md
# Scaled Watchdog Countdown Timer

This block is an 8-bit watchdog countdown timer driven by three small configuration registers: an option register, a count register and a control register. Software arms the timer by writing a nonzero count. A prescaler fed by an external tick input turns ticks into timer units, either one tick per unit or a long unit of sixty ticks. The live count falls by one at each unit. When it reaches zero the block raises a sticky fired flag and gives a one-cycle timeout pulse on a selectable interrupt line.

Software keeps the timer from expiring by rewriting the count. When enabled, mouse and keyboard interrupt events can also reload the last written count. Software can force an immediate timeout through a self-clearing control bit, and a keyboard pin input can force one when its enable bit is set. After a timeout the fired flag must be cleared by software before another timeout pulse can be produced.

Top module: `wdt_scaled`

## Requirements
- R1: After reset all three registers read 0, timeout_o is low and irq_o is all zeros.
- R2: Writing the count register (cfg_addr 1) loads that value into the live count, which reads back at the same address. A value of 0 stops the timer, and no timeout follows however many ticks arrive.
- R3: With option bit 3 clear, the live count drops by one on each cycle with tick_i high. A count of N written with tick_i then held high gives the timeout exactly N cycles after the write edge.
- R4: With option bit 3 set (option register at cfg_addr 0), one unit lasts 60 ticks, so a count of N expires 60*N ticked cycles after the write edge.
- R5: Any reload, whether a count write or an event reload, restarts the prescaler, so the first unit after a reload is a full period.
- R6: On expiry the live count stays at 0, control bit 4 (fired) reads 1, and timeout_o is high for exactly one cycle.
- R7: The timeout pulse appears on irq_o at the line chosen by control bits 3:0, as a one-hot vector in the same cycle as timeout_o. Value 2 selects line 2, the system-management line.
- R8: With control bit 7 set, a mouse_irq_i pulse reloads the last written count. With bit 7 clear, the pulse has no effect.
- R9: With control bit 6 set, a kbd_irq_i pulse reloads the last written count. With bit 6 clear, the pulse has no effect.
- R10: Writing control bit 5 as 1 forces a timeout one cycle later. Bit 5 always reads back 0.
- R11: With option bit 2 set, a high kbd_pin_i forces a timeout. With bit 2 clear, the pin has no effect.
- R12: The fired flag is sticky. While it is set, no expiry or force produces a pulse. Writing control bit 4 as 0 clears it, and writing it as 1 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 option, 1 count, 2 control |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the selected register (combinational) |
| tick_i | input | 1 | Time-base tick, one cycle per tick |
| mouse_irq_i | input | 1 | Mouse interrupt event |
| kbd_irq_i | input | 1 | Keyboard interrupt event |
| kbd_pin_i | input | 1 | Keyboard force-timeout pin |
| timeout_o | output | 1 | One-cycle timeout pulse |
| irq_o | output | IRQ_LINES | Timeout pulse routed to the selected line |

## Verification
Every result is registered exactly once. A register write is visible on cfg_rdata in the cycle after its write edge. A forced timeout shows on timeout_o and irq_o in the cycle after the forcing edge. A count of N with tick held high first shows its pulse N cycles after the write edge in the short unit, and 60*N cycles after it in the long unit. The bench drives at falling edges and samples at the following falling edge, so each sample lies half a period after the edge that produced it. It also counts cycles from the load edge to the first pulse and compares that count with the value it computes from N, the unit and any reload point.

// File: rtl/wdt_scaled_pkg.sv
`timescale 1ns/1ps
package wdt_scaled_pkg;
  typedef enum logic [1:0] {
    CFG_OPT   = 2'd0,
    CFG_COUNT = 2'd1,
    CFG_CTRL  = 2'd2,
    CFG_NONE  = 2'd3
  } cfg_sel_e;

  localparam int OPT_LONG_BIT  = 3;
  localparam int OPT_PIN_BIT   = 2;
  localparam int CTL_MOUSE_BIT = 7;
  localparam int CTL_KBD_BIT   = 6;
  localparam int CTL_FORCE_BIT = 5;
  localparam int CTL_FIRED_BIT = 4;
  localparam int SEL_W         = 4;

  // ticks per timer unit
  function automatic int unsigned unit_period(input logic long_sel,
                                              input int unsigned long_units);
    return long_sel ? long_units : 32'd1;
  endfunction
endpackage

// File: rtl/wdt_prescale.sv
`timescale 1ns/1ps
module wdt_prescale
  import wdt_scaled_pkg::*;
#(
  parameter int unsigned LONG_UNITS = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic run_i,
  input  logic restart_i,
  input  logic long_i,
  output logic step_o
);
  localparam int PW = (LONG_UNITS > 1) ? $clog2(LONG_UNITS) : 1;

  logic [PW-1:0] pre_q;
  logic [31:0]   per_m1;
  logic          at_end;

  assign per_m1 = unit_period(long_i, LONG_UNITS) - 32'd1;
  assign at_end = 32'(pre_q) >= per_m1;
  assign step_o = run_i & tick_i & ~restart_i & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pre_q <= '0;
    else if (restart_i || !run_i) pre_q <= '0;
    else if (tick_i)            pre_q <= at_end ? '0 : pre_q + 1'b1;
  end

  assert_pre_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pre_q) < LONG_UNITS || LONG_UNITS == 1);
  assert_restart_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> pre_q == '0);
endmodule

// File: rtl/wdt_countdown.sv
`timescale 1ns/1ps
module wdt_countdown #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          force_i,
  input  logic          step_i,
  output logic [CW-1:0] cnt_o,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;

  assign cnt_o    = cnt_q;
  assign expire_o = step_i & (cnt_q == CW'(1)) & ~load_i & ~force_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (load_i)               cnt_q <= load_val_i;
    else if (force_i)              cnt_q <= '0;
    else if (step_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assert_load_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_q == $past(load_val_i));
  assert_dec_by_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && !force_i && cnt_q != 0) |=> cnt_q == $past(cnt_q) - 1'b1);
  assert_hold_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == 0 && !load_i) |=> cnt_q == 0);
endmodule

// File: rtl/wdt_status.sv
`timescale 1ns/1ps
module wdt_status
  import wdt_scaled_pkg::*;
#(
  parameter int IRQ_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_we,
  input  logic                 wr_mouse_en,
  input  logic                 wr_kbd_en,
  input  logic                 wr_keep_fired,
  input  logic [SEL_W-1:0]     wr_sel,
  input  logic                 expire_i,
  input  logic                 force_i,
  output logic                 mouse_en_o,
  output logic                 kbd_en_o,
  output logic                 fired_o,
  output logic [SEL_W-1:0]     sel_o,
  output logic                 timeout_o,
  output logic [IRQ_LINES-1:0] irq_o
);
  logic                 mouse_en_q, kbd_en_q, fired_q, timeout_q;
  logic [SEL_W-1:0]     sel_q, sel_next;
  logic [IRQ_LINES-1:0] irq_q, line_hit;
  logic                 fired_kept, fire_evt;

  assign fired_kept = fired_q & ~(ctl_we & ~wr_keep_fired);
  assign fire_evt   = (expire_i | force_i) & ~fired_kept;
  assign sel_next   = ctl_we ? wr_sel : sel_q;

  for (genvar g = 0; g < IRQ_LINES; g++) begin : g_route
    assign line_hit[g] = (sel_next == SEL_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mouse_en_q <= 1'b0;
      kbd_en_q   <= 1'b0;
      sel_q      <= '0;
      fired_q    <= 1'b0;
      timeout_q  <= 1'b0;
      irq_q      <= '0;
    end else begin
      if (ctl_we) begin
        mouse_en_q <= wr_mouse_en;
        kbd_en_q   <= wr_kbd_en;
        sel_q      <= wr_sel;
      end
      fired_q   <= fired_kept | fire_evt;
      timeout_q <= fire_evt;
      irq_q     <= fire_evt ? line_hit : '0;
    end
  end

  assign mouse_en_o = mouse_en_q;
  assign kbd_en_o   = kbd_en_q;
  assign fired_o    = fired_q;
  assign sel_o      = sel_q;
  assign timeout_o  = timeout_q;
  assign irq_o      = irq_q;

  assert_pulse_sets_fired_R6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_q |-> fired_q);
  assert_irq_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_q));
  assert_irq_with_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q != '0) |-> timeout_q);
  assert_fired_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (fired_q && !(ctl_we && !wr_keep_fired)) |=> fired_q);
endmodule

// File: rtl/wdt_scaled.sv
`timescale 1ns/1ps
module wdt_scaled
  import wdt_scaled_pkg::*;
#(
  parameter int          CW         = 8,
  parameter int unsigned LONG_UNITS = 60,
  parameter int          IRQ_LINES  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_addr,
  input  logic [CW-1:0]        cfg_wdata,
  output logic [CW-1:0]        cfg_rdata,
  input  logic                 tick_i,
  input  logic                 mouse_irq_i,
  input  logic                 kbd_irq_i,
  input  logic                 kbd_pin_i,
  output logic                 timeout_o,
  output logic [IRQ_LINES-1:0] irq_o
);
  cfg_sel_e         sel;
  logic [CW-1:0]    opt_q, reload_q, cnt;
  logic             wr_opt, wr_cnt, wr_ctl;
  logic             mouse_en, kbd_en, fired;
  logic [SEL_W-1:0] irq_sel;
  logic             load_en, force_req, step, expire;
  logic [CW-1:0]    load_val;

  assign sel    = cfg_sel_e'(cfg_addr);
  assign wr_opt = cfg_we && sel == CFG_OPT;
  assign wr_cnt = cfg_we && sel == CFG_COUNT;
  assign wr_ctl = cfg_we && sel == CFG_CTRL;

  assign load_en   = wr_cnt | (mouse_irq_i & mouse_en) | (kbd_irq_i & kbd_en);
  assign load_val  = wr_cnt ? cfg_wdata : reload_q;
  assign force_req = (wr_ctl & cfg_wdata[CTL_FORCE_BIT])
                   | (opt_q[OPT_PIN_BIT] & kbd_pin_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opt_q    <= '0;
      reload_q <= '0;
    end else begin
      if (wr_opt) opt_q    <= cfg_wdata;
      if (wr_cnt) reload_q <= cfg_wdata;
    end
  end

  wdt_prescale #(.LONG_UNITS(LONG_UNITS)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(cnt != '0),
    .restart_i(load_en), .long_i(opt_q[OPT_LONG_BIT]), .step_o(step)
  );

  wdt_countdown #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(load_en), .load_val_i(load_val),
    .force_i(force_req), .step_i(step), .cnt_o(cnt), .expire_o(expire)
  );

  wdt_status #(.IRQ_LINES(IRQ_LINES)) u_stat (
    .clk(clk), .rst_n(rst_n), .ctl_we(wr_ctl),
    .wr_mouse_en(cfg_wdata[CTL_MOUSE_BIT]), .wr_kbd_en(cfg_wdata[CTL_KBD_BIT]),
    .wr_keep_fired(cfg_wdata[CTL_FIRED_BIT]), .wr_sel(cfg_wdata[SEL_W-1:0]),
    .expire_i(expire), .force_i(force_req),
    .mouse_en_o(mouse_en), .kbd_en_o(kbd_en), .fired_o(fired), .sel_o(irq_sel),
    .timeout_o(timeout_o), .irq_o(irq_o)
  );

  always_comb begin
    cfg_rdata = '0;
    unique case (sel)
      CFG_OPT:   cfg_rdata = opt_q;
      CFG_COUNT: cfg_rdata = cnt;
      CFG_CTRL: begin
        cfg_rdata[CTL_MOUSE_BIT] = mouse_en;
        cfg_rdata[CTL_KBD_BIT]   = kbd_en;
        cfg_rdata[CTL_FIRED_BIT] = fired;
        cfg_rdata[SEL_W-1:0]     = irq_sel;
      end
      default:   cfg_rdata = '0;
    endcase
  end

  assert_zero_count_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> !step);
  assert_pin_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!opt_q[OPT_PIN_BIT] && !wr_ctl && !load_en && cnt != '0 && !step) |=> cnt == $past(cnt));
endmodule

// File: tb/sim_wdt_scaled.sv
`timescale 1ns/1ps
module sim_wdt_scaled;
  localparam int LONG = 60;
  localparam logic [1:0] A_OPT = 2'd0, A_CNT = 2'd1, A_CTL = 2'd2;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [7:0]  cfg_wdata = 8'd0;
  logic [7:0]  cfg_rdata;
  logic        tick_i = 1'b0, mouse_irq_i = 1'b0, kbd_irq_i = 1'b0, kbd_pin_i = 1'b0;
  logic        timeout_o;
  logic [15:0] irq_o;

  int nchecks = 0, nerrs = 0;

  always #4 clk = ~clk;

  wdt_scaled u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .tick_i(tick_i),
    .mouse_irq_i(mouse_irq_i), .kbd_irq_i(kbd_irq_i), .kbd_pin_i(kbd_pin_i),
    .timeout_o(timeout_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchecks++;
    if (act != exp) begin
      nerrs++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    cfg_addr = a;
    #1;
    d = int'(cfg_rdata);
  endtask

  // counts cycles from the current falling edge to the first sampled pulse
  task automatic wait_fire(input int limit, output int cyc, output bit seen);
    cyc = 0; seen = 0;
    while (!seen && cyc < limit) begin
      @(negedge clk);
      cyc++;
      if (timeout_o) seen = 1;
    end
  endtask

  function automatic int expect_cycles(input int n, input bit long_u);
    return n * (long_u ? LONG : 1);
  endfunction

  task automatic run_fire(input int n, input bit long_u, input int sel, input string req);
    int cyc, v; bit seen;
    tick_i = 1'b0;
    wr(A_OPT, long_u ? 8'h08 : 8'h00);
    wr(A_CTL, {4'b0000, 4'(sel)});           // clears fired, events off
    wr(A_CNT, 8'(n));
    tick_i = 1'b1;
    wait_fire(expect_cycles(n, long_u) + 5, cyc, seen);
    chk({req, " fire delay"}, cyc, expect_cycles(n, long_u));
    chk("R7 irq line", int'(irq_o), 1 << sel);
    rd(A_CNT, v); chk("R6 count held at zero", v, 0);
    rd(A_CTL, v); chk("R6 fired flag", (v >> 4) & 1, 1);
    @(negedge clk);
    chk("R6 single-cycle pulse", int'(timeout_o), 0);
    tick_i = 1'b0;
  endtask

  initial begin
    #1_200_000;
    nchecks++; nerrs++;
    $display("FAIL watchdog actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
    $finish;
  end

  initial begin
    int v, cyc; bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(A_OPT, v); chk("R1 option reset", v, 0);
    rd(A_CNT, v); chk("R1 count reset", v, 0);
    rd(A_CTL, v); chk("R1 control reset", v, 0);
    chk("R1 timeout low", int'(timeout_o), 0);
    chk("R1 irq low", int'(irq_o), 0);

    // R2 live readback and zero disables
    wr(A_CNT, 8'd10); tick_i = 1'b1;
    repeat (3) @(negedge clk);
    rd(A_CNT, v); chk("R2 live count", v, 7);
    wr(A_CNT, 8'd0);
    wait_fire(50, cyc, seen);
    chk("R2 zero stops timer", int'(seen), 0);
    rd(A_CNT, v); chk("R2 count stays zero", v, 0);
    tick_i = 1'b0;

    // R3 short-unit sweep
    for (int n = 1; n <= 10; n++) run_fire(n, 1'b0, 2, "R3");
    run_fire(255, 1'b0, 9, "R3 max");
    // R4 long-unit sweep
    for (int n = 1; n <= 3; n++) run_fire(n, 1'b1, 5, "R4");
    run_fire(255, 1'b1, 1, "R4 max");

    // R5 prescaler restart on rewrite mid-period
    wr(A_OPT, 8'h08); wr(A_CTL, 8'h02);
    wr(A_CNT, 8'd2); tick_i = 1'b1;
    repeat (29) @(negedge clk);
    wr(A_CNT, 8'd2);
    wait_fire(200, cyc, seen);
    chk("R5 full period after reload", cyc, 120);
    tick_i = 1'b0;

    // R8 mouse reload enabled / disabled
    for (int en = 0; en < 2; en++) begin
      wr(A_OPT, 8'h00);
      wr(A_CTL, en ? 8'h80 : 8'h00);
      wr(A_CNT, 8'd6); tick_i = 1'b1;
      @(negedge clk); @(negedge clk);
      mouse_irq_i = 1'b1; @(negedge clk); mouse_irq_i = 1'b0;
      wait_fire(20, cyc, seen);
      chk(en ? "R8 mouse reload" : "R8 mouse ignored", cyc, en ? 6 : 3);
      tick_i = 1'b0;
    end
    // R9 keyboard reload enabled / disabled
    for (int en = 0; en < 2; en++) begin
      wr(A_CTL, en ? 8'h40 : 8'h00);
      wr(A_CNT, 8'd6); tick_i = 1'b1;
      @(negedge clk); @(negedge clk);
      kbd_irq_i = 1'b1; @(negedge clk); kbd_irq_i = 1'b0;
      wait_fire(20, cyc, seen);
      chk(en ? "R9 keyboard reload" : "R9 keyboard ignored", cyc, en ? 6 : 3);
      tick_i = 1'b0;
    end

    // R10 + R7 force sweep over every line
    for (int s = 0; s < 16; s++) begin
      wr(A_CTL, {4'b0010, 4'(s)});
      chk("R10 forced pulse", int'(timeout_o), 1);
      chk("R7 routed line", int'(irq_o), 1 << s);
      rd(A_CTL, v);
      chk("R10 force bit reads 0", (v >> 5) & 1, 0);
    end

    // R12 sticky fired blocks new pulse
    wr(A_CNT, 8'd3); tick_i = 1'b1;
    wait_fire(6, cyc, seen);
    chk("R12 no pulse while fired", int'(seen), 0);
    rd(A_CNT, v); chk("R12 count expired", v, 0);
    wr(A_CTL, 8'h12);
    rd(A_CTL, v); chk("R12 write 1 keeps fired", (v >> 4) & 1, 1);
    wr(A_CTL, 8'h02);
    rd(A_CTL, v); chk("R12 write 0 clears", (v >> 4) & 1, 0);
    wr(A_CNT, 8'd3);
    wait_fire(10, cyc, seen);
    chk("R12 fires again", cyc, 3);
    tick_i = 1'b0;

    // R11 keyboard pin force enabled
    wr(A_OPT, 8'h04); wr(A_CTL, 8'h02);
    wr(A_CNT, 8'd20);
    kbd_pin_i = 1'b1; @(negedge clk); kbd_pin_i = 1'b0;
    chk("R11 pin forces", int'(timeout_o), 1);
    rd(A_CNT, v); chk("R11 count zero", v, 0);
    // R11 pin ignored when disabled
    wr(A_OPT, 8'h00); wr(A_CTL, 8'h02);
    wr(A_CNT, 8'd20); tick_i = 1'b1; kbd_pin_i = 1'b1;
    wait_fire(3, cyc, seen);
    kbd_pin_i = 1'b0; tick_i = 1'b0;
    chk("R11 pin ignored", int'(seen), 0);
    rd(A_CNT, v); chk("R11 count unaffected", v, 17);

    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
    $finish;
  end
endmodule